// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous static RAM with a pipelined read path and four-beat bursts. Each word is split into byte lanes. All address, select, burst and write controls are sampled on the rising clock edge. A burst opens on either of two address strobes: a processor-side strobe, which always starts a read, or a controller-side strobe, which may start a read or a write. Later beats of the burst come from an internal 2-bit counter that moves on an advance input. The beat order is linear or interleaved, chosen by a mode input.

Writes are self-timed. Address, data and lane mask are registered at the edge that accepts the access, and the array is updated at the following edge. A write covers the lanes that a byte-write enable selects, or every lane when the global write is active. Read data passes through a stage register and then an output register. The output is gated combinationally by an active-low output enable. Three chip selects allow depth expansion, and a deselect takes effect on the cycle it is sampled. A power-down input suspends all accesses.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is selected only when cs1_n=0, cs2=1 and cs3_n=0. A strobe sampled while the device is not selected makes no access and ends any open burst, so a later advance makes no access either.
- R2: A selected strobe cycle accesses the word at `addr`, stores `addr` as the burst base and resets the beat count to 0.
- R3: An advance (adv_n=0) with no strobe steps the beat count by 1, modulo 4, and accesses the next beat. An advance with no open burst (after reset, a deselect or power-down) makes no access.
- R4: With order=0 (linear), beat n accesses the word whose two low address bits are (base[1:0] + n) mod 4. The upper address bits are those of the base.
- R5: With order=1 (interleaved), beat n accesses the word whose two low address bits are base[1:0] XOR n. The upper address bits are those of the base.
- R6: A cycle opened by the processor strobe (proc_stb_n=0) is always a read, whatever the write controls are. When both strobes are asserted together, the processor strobe wins.
- R7: In a controller-strobe cycle or an advance cycle, with allwr_n=1 and bytewr_n=0, lane i (wdata bits [9i+8:9i]) is written exactly when lane_we_n[i]=0. The other lanes keep their contents.
- R8: allwr_n=0 in a controller-strobe cycle or an advance cycle writes all four lanes, whatever bytewr_n and lane_we_n are.
- R9: A controller-strobe cycle or an advance cycle that enables no lane is a read.
- R10: Read data for an access sampled at edge k appears after edge k+1 with rvalid=1. It stays for one cycle unless another read follows.
- R11: When oe_n=1, rvalid is 0 and rdata is all zeros, at once and without waiting for a clock edge.
- R12: If a strobe and an advance are sampled in the same cycle, the strobe takes priority and reloads the base address.
- R13: While sleep=1, no access takes place and any open burst is closed.
- R14: After a synchronous reset, rvalid is 0, rdata is zero and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down: suspends accesses |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| order | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| bytewr_n | input | 1 | Byte-write enable, active low |
| allwr_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with its defaults: ADDR_W=8, LANES=4 and LANE_W=9, which gives a 256-word array of 36-bit words. At that depth every word can be loaded before any read, so each read result is well defined. Bursts can start at every low-bit offset, so wrap-around in both orders is exercised. With four lanes, all sixteen lane masks are reachable, including the empty mask that turns a write into a read. The pseudo-random phase mixes strobes, advances, deselects, power-down and output-enable toggles over the whole address range.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic       open;
        logic [1:0] beat;
    } burst_t;

    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] beat,
                                               input order_e     ord);
        logic [1:0] r;
        if (ord == ORD_INTERLEAVE) r = base ^ beat;
        else                       r = base + beat;
        return r;
    endfunction

    function automatic logic chip_selected(input logic s1_n,
                                           input logic s2,
                                           input logic s3_n);
        return (!s1_n) && s2 && (!s3_n);
    endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              order,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              bytewr_n,
    input  logic              allwr_n,
    output acc_e              acc_kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);

    burst_t             bst_q;
    logic [ADDR_W-1:0]  base_q;

    logic               stb, sel, adv, start, step, wr_req;
    logic [1:0]         nxt_beat;
    logic [LANES-1:0]   mask;
    order_e             ord;

    always_comb begin
        ord      = order_e'(order);
        stb      = !proc_stb_n || !ctrl_stb_n;
        sel      = chip_selected(cs1_n, cs2, cs3_n);
        adv      = !adv_n;
        start    = !sleep && stb && sel;
        step     = !sleep && !stb && adv && bst_q.open;
        nxt_beat = bst_q.beat + 2'd1;
        if (!allwr_n)       mask = '1;
        else if (!bytewr_n) mask = ~lane_we_n;
        else                mask = '0;
        wr_req   = |mask;

        acc_kind = ACC_NONE;
        acc_addr = addr;
        acc_mask = '0;
        if (start) begin
            acc_addr = addr;
            if (!proc_stb_n || !wr_req) begin
                acc_kind = ACC_READ;
            end else begin
                acc_kind = ACC_WRITE;
                acc_mask = mask;
            end
        end else if (step) begin
            acc_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], nxt_beat, ord)};
            if (wr_req) begin
                acc_kind = ACC_WRITE;
                acc_mask = mask;
            end else begin
                acc_kind = ACC_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bst_q  <= '0;
            base_q <= '0;
        end else if (sleep || (stb && !sel)) begin
            bst_q.open <= 1'b0;
        end else if (start) begin
            bst_q.open <= 1'b1;
            bst_q.beat <= 2'd0;
            base_q     <= addr;
        end else if (step) begin
            bst_q.beat <= nxt_beat;
        end
    end

    // R3
    adv_no_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (!bst_q.open && proc_stb_n && ctrl_stb_n && !adv_n) |-> (acc_kind == ACC_NONE));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bst_q.open && proc_stb_n && ctrl_stb_n && !adv_n && !sleep)
        |=> (bst_q.beat == $past(bst_q.beat) + 2'd1));

    // R1
    desel_close_chk: assert property (@(posedge clk) disable iff (rst)
        ((!proc_stb_n || !ctrl_stb_n) && (cs1_n || !cs2 || cs3_n))
        |=> !bst_q.open);

    // R6
    proc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && !cs1_n && cs2 && !cs3_n && !sleep) |-> (acc_kind == ACC_READ));

    // R8
    glob_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == ACC_WRITE && !allwr_n) |-> (&acc_mask));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_e                    acc_kind,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        acc_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    rd_v,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic                    wr_v_q;
    logic [ADDR_W-1:0]       wr_addr_q;
    logic [LANES-1:0]        wr_mask_q;
    logic [LANES*LANE_W-1:0] wr_data_q;
    logic                    rd_v_q;
    logic [ADDR_W-1:0]       rd_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_v_q    <= 1'b0;
            rd_v_q    <= 1'b0;
            wr_addr_q <= '0;
            wr_mask_q <= '0;
            wr_data_q <= '0;
            rd_addr_q <= '0;
        end else begin
            wr_v_q    <= (acc_kind == ACC_WRITE);
            rd_v_q    <= (acc_kind == ACC_READ);
            wr_addr_q <= acc_addr;
            wr_mask_q <= acc_mask;
            wr_data_q <= wdata;
            rd_addr_q <= acc_addr;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_v_q && wr_mask_q[g]) begin
                mem[wr_addr_q] <= wr_data_q[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr_q];
    end

    assign rd_v = rd_v_q;

    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_v_q && rd_v_q));

endmodule

// File: rtl/sbsram_outreg.sv
module sbsram_outreg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_v,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic              out_v_q;
    logic [DATA_W-1:0] out_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v_q <= 1'b0;
            out_d_q <= '0;
        end else begin
            out_v_q <= rd_v;
            if (rd_v) out_d_q <= rd_word;
        end
    end

    always_comb begin
        rvalid = out_v_q && !oe_n;
        rdata  = rvalid ? out_d_q : '0;
    end

    // R10
    rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
        rd_v |=> out_v_q);

    // R10
    rd_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_v |=> !out_v_q);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  logic                    proc_stb_n,
    input  logic                    ctrl_stb_n,
    input  logic                    adv_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    order,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    bytewr_n,
    input  logic                    allwr_n,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    acc_e              acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic              rd_v;
    logic [DATA_W-1:0] rd_word;

    sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .order(order),
        .addr(addr), .lane_we_n(lane_we_n), .bytewr_n(bytewr_n), .allwr_n(allwr_n),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_mask(acc_mask)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst(rst), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_mask(acc_mask), .wdata(wdata), .rd_v(rd_v), .rd_word(rd_word)
    );

    sbsram_outreg #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .rd_v(rd_v), .rd_word(rd_word),
        .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!rvalid && rdata == '0));

    // R13
    sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !rd_v);

endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;

    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int NL     = 4;
    localparam int LW     = 9;
    localparam int DW     = NL * LW;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep = 1'b0;
    logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic          order = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NL-1:0] lane_we_n = '1;
    logic          bytewr_n = 1'b1, allwr_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag = "R14";

    always #(PERIOD/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
        .clk(clk), .rst(rst), .sleep(sleep),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .order(order),
        .addr(addr), .wdata(wdata), .lane_we_n(lane_we_n),
        .bytewr_n(bytewr_n), .allwr_n(allwr_n), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    // behavioural reference
    logic [DW-1:0] mm [DEPTH];
    int            m_base = 0, m_cnt = 0, s1a = 0;
    bit            m_open = 0, s1v = 0, ov = 0;
    logic [DW-1:0] od = '0;

    always @(posedge clk) begin
        bit            st, sel, acc, wr, nov;
        int            a, lo;
        logic [NL-1:0] en;
        logic [DW-1:0] nod;
        if (rst) begin
            m_open = 0; m_cnt = 0; s1v = 0; ov = 0; od = '0;
        end else begin
            nov = s1v;
            nod = s1v ? mm[s1a] : od;
            st  = !proc_stb_n || !ctrl_stb_n;
            sel = !cs1_n && cs2 && !cs3_n;
            if (!allwr_n)       en = '1;
            else if (!bytewr_n) en = ~lane_we_n;
            else                en = '0;
            acc = 0; wr = 0; a = 0;
            if (sleep) m_open = 0;
            else if (st && !sel) m_open = 0;
            else if (st) begin
                m_open = 1; m_base = int'(addr); m_cnt = 0; acc = 1; a = int'(addr);
                wr = proc_stb_n && (en != 0);
            end else if (!adv_n && m_open) begin
                m_cnt = (m_cnt + 1) % 4;
                if (order) lo = (m_base % 4) ^ m_cnt;
                else       lo = ((m_base % 4) + m_cnt) % 4;
                a = (m_base / 4) * 4 + lo;
                acc = 1;
                wr = (en != 0);
            end
            if (acc && wr)
                for (int i = 0; i < NL; i++)
                    if (en[i]) mm[a][i*LW +: LW] = wdata[i*LW +: LW];
            s1v = acc && !wr;
            s1a = a;
            ov  = nov;
            od  = nod;
        end
    end

    task automatic compare();
        logic [DW-1:0] er;
        bit            ev;
        ev = ov && !oe_n;
        er = ev ? od : '0;
        checks++;
        if (rvalid !== ev || rdata !== er) begin
            errors++;
            $display("FAIL %s rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, er);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        lane_we_n = '1; bytewr_n = 1; allwr_n = 1;
    endtask

    task automatic pstb(input int a);
        idle_in(); proc_stb_n = 0; addr = AW'(a); cyc();
    endtask

    task automatic cstb(input int a);
        proc_stb_n = 1; adv_n = 1; ctrl_stb_n = 0; addr = AW'(a); cyc();
    endtask

    task automatic advc();
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 0; cyc();
    endtask

    task automatic gap(input int n);
        idle_in();
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf;
        // R14 reset state
        repeat (3) @(negedge clk);
        tag = "R14";
        compare();
        rst = 0;
        gap(2);

        // R8 fill with global writes; lane enables deliberately all off
        tag = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            idle_in(); allwr_n = 0; bytewr_n = 1; lane_we_n = '1;
            wdata = {DW{1'b0}} | (DW'(a) * 36'h0_1357_9BDF) ^ 36'h5_A5A5_A5A5;
            cstb(a);
        end
        gap(2);

        // R4 linear burst from offset 1 (wraps)
        tag = "R4";
        order = 0;
        pstb(33); advc(); advc(); advc(); gap(3);
        pstb(46); advc(); advc(); advc(); advc(); gap(3);

        // R5 interleaved burst from offset 2 and 3
        tag = "R5";
        order = 1;
        pstb(70); advc(); advc(); advc(); gap(3);
        pstb(75); advc(); advc(); advc(); gap(3);
        order = 0;

        // R7 byte-lane writes via controller strobe then advances
        tag = "R7";
        idle_in(); bytewr_n = 0; lane_we_n = 4'b1010; wdata = 36'hF_0F0F_0F0F; cstb(100);
        bytewr_n = 0; lane_we_n = 4'b0111; wdata = 36'h1_2345_6789; advc();
        bytewr_n = 0; lane_we_n = 4'b0000; wdata = 36'hA_BCDE_F012; advc();
        gap(2);
        pstb(100); advc(); advc(); advc(); gap(3);

        // R8 global write overrides lane enables during a burst
        tag = "R8";
        idle_in(); allwr_n = 0; bytewr_n = 0; lane_we_n = 4'b1110; wdata = 36'h9_8765_4321; cstb(120);
        allwr_n = 0; bytewr_n = 1; lane_we_n = 4'b1111; wdata = 36'h3_3333_3333; advc();
        gap(2); pstb(120); advc(); gap(3);

        // R6 processor strobe with write controls is a read; both strobes together
        tag = "R6";
        idle_in(); allwr_n = 0; wdata = 36'hD_EADB_EEF0;
        proc_stb_n = 0; addr = 8'd140; cyc();
        idle_in(); allwr_n = 0; wdata = 36'hC_0FFE_E000;
        proc_stb_n = 0; ctrl_stb_n = 0; addr = 8'd141; cyc();
        gap(2); pstb(140); advc(); gap(3);

        // R9 no lane enabled: treated as a read
        tag = "R9";
        idle_in(); bytewr_n = 1; allwr_n = 1; lane_we_n = 4'b0000; wdata = 36'h0_BAD0_BAD0; cstb(150);
        bytewr_n = 0; lane_we_n = 4'b1111; advc();
        gap(2); pstb(150); advc(); gap(3);

        // R10 back-to-back reads, single-cycle gaps
        tag = "R10";
        pstb(10); gap(1); pstb(11); pstb(12); gap(1); advc(); gap(3);

        // R1 deselect through each chip select
        tag = "R1";
        pstb(20); advc();
        idle_in(); cs1_n = 1; proc_stb_n = 0; addr = 8'd30; cyc();
        idle_in(); advc(); advc(); gap(2);
        pstb(21);
        idle_in(); cs2 = 0; ctrl_stb_n = 0; allwr_n = 0; addr = 8'd21; wdata = '1; cyc();
        idle_in(); advc(); gap(2);
        idle_in(); cs3_n = 1; proc_stb_n = 0; addr = 8'd22; cyc();
        idle_in(); advc(); gap(2);
        pstb(21); gap(3);

        // R3 advance with no open burst after reset
        tag = "R3";
        rst = 1; gap(2); rst = 0;
        advc(); advc(); gap(2);
        pstb(50); advc(); advc(); advc(); advc(); advc(); gap(3);

        // R12 strobe and advance together reload the base
        tag = "R12";
        pstb(60); advc();
        proc_stb_n = 0; adv_n = 0; addr = 8'd90; cyc();
        advc(); gap(3);

        // R11 output enable gates the data
        tag = "R11";
        pstb(80); advc(); oe_n = 1; advc(); advc(); oe_n = 0; gap(1); oe_n = 1; gap(1); oe_n = 0; gap(2);

        // R13 sleep closes the burst and blocks accesses
        tag = "R13";
        pstb(84); advc(); sleep = 1; advc(); pstb(85); sleep = 0; advc(); gap(3);

        // R2 pseudo-random mix
        tag = "R2";
        lf = 32'hACE1_2B3D;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            idle_in();
            wdata     = {lf[3:0], lf};
            lane_we_n = lf[7:4];
            bytewr_n  = lf[8];
            allwr_n   = lf[9] | lf[10];
            oe_n      = (lf[13:11] == 3'd0);
            sleep     = (lf[18:14] == 5'd0);
            addr      = lf[26:19];
            case (lf[29:27])
                3'd0: begin proc_stb_n = 0; order = lf[30]; end
                3'd1: begin ctrl_stb_n = 0; order = lf[30]; end
                3'd2, 3'd3, 3'd4, 3'd5: adv_n = 0;
                3'd6: ;
                default: begin
                    proc_stb_n = lf[30]; ctrl_stb_n = !lf[30];
                    cs2 = 0; adv_n = lf[31];
                end
            endcase
            cyc();
        end
        sleep = 0; oe_n = 0;
        gap(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule